// File: doc/BRIEF.md
# Bus Hold Request Handshake

This block lets an external bus master take over the bus. It runs a small bus state machine with idle, address, data and hold states. It takes in an asynchronous hold request and brings it into the clock domain through a chain of synchronising flops. It then waits for a safe point: the bus is idle, or the sequencer reports a cycle boundary during a data phase, and no read-modify-write lock is held. At that point it floats the three-state bus outputs and only then raises the hold acknowledge.

When the request goes away, the acknowledge drops first. The float enable stays on for one more cycle, and then the bus is driven again. The machine goes back to idle, or straight into an address phase if the sequencer has an access waiting. The hold acknowledge is always driven and never floats. Every output comes straight from a flop.

Top module: `bus_hold_handshake`

## Requirements
- R1: While `rst` is high, and after reset until a request is granted, `hold_ack` is 0, `bus_float` is 0 and `bus_state` is idle (2'd0).
- R2: The hold request passes through `SYNC_STAGES` flops (default 2). If `hold_req` rises before clock edge k while the bus is idle and unlocked, `bus_float` is still 0 after edge k+SYNC_STAGES-1 and becomes 1 after edge k+SYNC_STAGES.
- R3: `bus_float` is 1 in the cycle before `hold_ack` rises and for as long as `hold_ack` is 1. `hold_ack` rises one cycle after `bus_float`. During that float-only cycle `bus_state` reads idle.
- R4: If `hold_req` falls before edge k while the bus is in hold, `hold_ack` is still 1 after edge k+SYNC_STAGES-1 and is 0 after edge k+SYNC_STAGES. `bus_float` stays 1 for that one cycle and returns to 0 one cycle after `hold_ack` falls.
- R5: At the end of the release cycle, `bus_state` goes to address (2'd1) if `access_pending` is 1 in that cycle, and to idle (2'd0) otherwise.
- R6: While `bus_state` is data (2'd2) and `at_boundary` is 0, the state stays data and no float or acknowledge starts, even with a synchronised hold request.
- R7: In data, with `at_boundary` at 1, a synchronised request and no lock, the next cycle has `bus_float`=1 and `hold_ack`=0. The cycle after that has `hold_ack`=1 and `bus_state` hold (2'd3).
- R8: While `lock_held` is 1, a hold request is not granted: `bus_float` and `hold_ack` stay 0. The grant begins in the first cycle after `lock_held` falls.
- R9: `bus_state` encodes idle=0, address=1, data=2, hold=3. In idle, a pending access with no grant enters address. Address lasts `ADDR_CYCLES` cycles (default 1) and then becomes data. Data at a boundary with no grant goes to address if an access is pending, and to idle otherwise. `hold_ack` is 1 exactly when `bus_state` is hold.
- R10: In idle, if a synchronised hold request and `access_pending` arrive in the same cycle, the hold request wins: the next state reads idle with `bus_float`=1, not address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req | input | 1 | Asynchronous bus request from the external master |
| access_pending | input | 1 | Sequencer has an access waiting |
| at_boundary | input | 1 | Current data cycle ends at a bus-cycle boundary |
| lock_held | input | 1 | A read-modify-write lock is held by this side |
| hold_ack | output | 1 | Bus released to the external master (always driven) |
| bus_float | output | 1 | Enable to float the three-state bus outputs |
| bus_state | output | 2 | Current bus state: 0 idle, 1 address, 2 data, 3 hold |

## Verification
Two things are hardest to reach from the ports. One is a request that arrives in the same cycle as a pending access. The other is a request held back in the middle of a data phase. For the first, the bench raises the request while nothing is pending. It counts the synchroniser delay and raises `access_pending` just before the edge where the synchronised request reaches the state machine, so both land together. For the second, it starts an access, holds `at_boundary` low for several cycles while the request is up, and only then raises the boundary to check that the grant follows on the next cycle. A held lock is tested the same way, by keeping the request up and then dropping the lock.

// File: rtl/bhh_pkg.sv
`timescale 1ns/1ps
package bhh_pkg;

  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_ADDR = 2'd1,
    BS_DATA = 2'd2,
    BS_HOLD = 2'd3
  } bus_state_t;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DATA  = 3'd2,
    PH_FLOAT = 3'd3,
    PH_HOLD  = 3'd4,
    PH_REL   = 3'd5
  } phase_t;

  function automatic bus_state_t phase_to_state(phase_t p);
    case (p)
      PH_ADDR: return BS_ADDR;
      PH_DATA: return BS_DATA;
      PH_HOLD: return BS_HOLD;
      default: return BS_IDLE;
    endcase
  endfunction

  function automatic logic phase_floats(phase_t p);
    return (p == PH_FLOAT) || (p == PH_HOLD) || (p == PH_REL);
  endfunction

endpackage

// File: rtl/bhh_sync.sv
`timescale 1ns/1ps
module bhh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bhh_fsm.sv
`timescale 1ns/1ps
module bhh_fsm
  import bhh_pkg::*;
#(
  parameter int ADDR_CYCLES = 1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   hold_sync,
  input  logic   access_pending,
  input  logic   at_boundary,
  input  logic   lock_held,
  output phase_t phase_q,
  output phase_t phase_d
);
  localparam int CW = (ADDR_CYCLES > 1) ? $clog2(ADDR_CYCLES) : 1;
  localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_CYCLES - 1);

  logic [CW-1:0] addr_cnt;
  logic          grant_ok;

  assign grant_ok = hold_sync && !lock_held;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: begin
        if (grant_ok)            phase_d = PH_FLOAT;
        else if (access_pending) phase_d = PH_ADDR;
      end
      PH_ADDR: begin
        if (addr_cnt == ADDR_LAST) phase_d = PH_DATA;
      end
      PH_DATA: begin
        if (at_boundary) begin
          if (grant_ok)            phase_d = PH_FLOAT;
          else if (access_pending) phase_d = PH_ADDR;
          else                     phase_d = PH_IDLE;
        end
      end
      PH_FLOAT: phase_d = PH_HOLD;
      PH_HOLD: begin
        if (!hold_sync) phase_d = PH_REL;
      end
      PH_REL: phase_d = access_pending ? PH_ADDR : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      addr_cnt <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_ADDR && phase_d == PH_ADDR) addr_cnt <= addr_cnt + 1'b1;
      else                                          addr_cnt <= '0;
    end
  end

  assert_no_grant_mid_data_R6: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DATA && !at_boundary) |=> (phase_q == PH_DATA));

  assert_lock_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (lock_held && (phase_q == PH_IDLE || phase_q == PH_DATA)) |=> (phase_q != PH_FLOAT));

  assert_resume_choice_R5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_REL) |=> (phase_q == ($past(access_pending) ? PH_ADDR : PH_IDLE)));

  assert_hold_priority_R10: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && hold_sync && !lock_held) |=> (phase_q == PH_FLOAT));
endmodule

// File: rtl/bhh_outreg.sv
`timescale 1ns/1ps
module bhh_outreg
  import bhh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  phase_t     phase_d,
  output logic       hold_ack,
  output logic       bus_float,
  output logic [1:0] bus_state
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_ack  <= 1'b0;
      bus_float <= 1'b0;
      bus_state <= BS_IDLE;
    end else begin
      hold_ack  <= (phase_d == PH_HOLD);
      bus_float <= phase_floats(phase_d);
      bus_state <= phase_to_state(phase_d);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!hold_ack && !bus_float && bus_state == BS_IDLE));

  assert_float_before_ack_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> $past(bus_float));

  assert_ack_implies_float_R3: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> bus_float);

  assert_float_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_ack) |-> bus_float);

  assert_ack_state_match_R9: assert property (@(posedge clk) disable iff (rst)
    hold_ack == (bus_state == BS_HOLD));
endmodule

// File: rtl/bus_hold_handshake.sv
`timescale 1ns/1ps
module bus_hold_handshake
  import bhh_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold_req,
  input  logic       access_pending,
  input  logic       at_boundary,
  input  logic       lock_held,
  output logic       hold_ack,
  output logic       bus_float,
  output logic [1:0] bus_state
);
  logic   hold_sync;
  phase_t phase_q;
  phase_t phase_d;

  bhh_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (hold_req),
    .q_sync  (hold_sync)
  );

  bhh_fsm #(.ADDR_CYCLES(ADDR_CYCLES)) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .hold_sync      (hold_sync),
    .access_pending (access_pending),
    .at_boundary    (at_boundary),
    .lock_held      (lock_held),
    .phase_q        (phase_q),
    .phase_d        (phase_d)
  );

  bhh_outreg u_out (
    .clk       (clk),
    .rst       (rst),
    .phase_d   (phase_d),
    .hold_ack  (hold_ack),
    .bus_float (bus_float),
    .bus_state (bus_state)
  );

  assert_release_float_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_float) |-> $past(!hold_ack));
endmodule

// File: tb/bus_hold_handshake_bench.sv
`timescale 1ns/1ps
module bus_hold_handshake_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_req = 1'b0, access_pending = 1'b0, at_boundary = 1'b0, lock_held = 1'b0;
  logic hold_ack, bus_float;
  logic [1:0] bus_state;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [1:0] S_IDLE = 2'd0, S_ADDR = 2'd1, S_DATA = 2'd2, S_HOLD = 2'd3;

  always #4 clk = ~clk;

  bus_hold_handshake u_bus_hold_handshake (
    .clk(clk), .rst(rst), .hold_req(hold_req), .access_pending(access_pending),
    .at_boundary(at_boundary), .lock_held(lock_held),
    .hold_ack(hold_ack), .bus_float(bus_float), .bus_state(bus_state)
  );

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic a, logic f, logic [1:0] s);
    n_chk++;
    if (hold_ack !== a || bus_float !== f || bus_state !== s) begin
      n_bad++;
      $display("FAIL %s: ack/float/state actual %b/%b/%0d expected %b/%b/%0d",
               req, hold_ack, bus_float, bus_state, a, f, s);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    tick(3);
    chk("R1 during reset", 0, 0, S_IDLE);
    rst = 1'b0;
    tick(2);
    chk("R1 after reset", 0, 0, S_IDLE);
  endtask

  task automatic t_release(bit pend);
    hold_req = 1'b0;
    tick(1);
    chk("R4 ack held edge k", 1, 1, S_HOLD);
    tick(1);
    chk("R4 ack held edge k+1", 1, 1, S_HOLD);
    access_pending = pend;
    tick(1);
    chk("R4 ack dropped float kept", 0, 1, S_IDLE);
    tick(1);
    chk(pend ? "R5 resume address" : "R5 resume idle", 0, 0, pend ? S_ADDR : S_IDLE);
  endtask

  task automatic t_grant_idle;
    hold_req = 1'b1;
    tick(1);
    chk("R2 not yet edge k", 0, 0, S_IDLE);
    tick(1);
    chk("R2 not yet edge k+1", 0, 0, S_IDLE);
    tick(1);
    chk("R3 float before ack", 0, 1, S_IDLE);
    tick(1);
    chk("R3 ack after float", 1, 1, S_HOLD);
    tick(3);
    chk("R9 stays hold", 1, 1, S_HOLD);
    t_release(0);
  endtask

  task automatic t_release_pending;
    hold_req = 1'b1;
    tick(4);
    chk("R3 hold reached", 1, 1, S_HOLD);
    t_release(1);
    tick(1);
    chk("R9 address to data", 0, 0, S_DATA);
    access_pending = 1'b0;
    at_boundary = 1'b0;
    tick(2);
    chk("R9 data waits boundary", 0, 0, S_DATA);
    at_boundary = 1'b1;
    tick(1);
    chk("R9 boundary to idle", 0, 0, S_IDLE);
    at_boundary = 1'b0;
  endtask

  task automatic t_data_block;
    access_pending = 1'b1;
    tick(1);
    chk("R9 idle to address", 0, 0, S_ADDR);
    access_pending = 1'b0;
    tick(1);
    chk("R9 address one cycle", 0, 0, S_DATA);
    hold_req = 1'b1;
    tick(5);
    chk("R6 no grant mid data", 0, 0, S_DATA);
    at_boundary = 1'b1;
    tick(1);
    chk("R7 float at boundary", 0, 1, S_IDLE);
    at_boundary = 1'b0;
    tick(1);
    chk("R7 ack after boundary", 1, 1, S_HOLD);
    t_release(0);
  endtask

  task automatic t_lock;
    lock_held = 1'b1;
    hold_req = 1'b1;
    tick(6);
    chk("R8 lock blocks grant", 0, 0, S_IDLE);
    lock_held = 1'b0;
    tick(1);
    chk("R8 grant after unlock", 0, 1, S_IDLE);
    tick(1);
    chk("R8 ack after unlock", 1, 1, S_HOLD);
    t_release(0);
  endtask

  task automatic t_priority;
    hold_req = 1'b1;
    tick(2);
    chk("R10 before collision", 0, 0, S_IDLE);
    access_pending = 1'b1;
    tick(1);
    chk("R10 hold wins over pending", 0, 1, S_IDLE);
    tick(1);
    chk("R10 hold entered", 1, 1, S_HOLD);
    t_release(1);
    access_pending = 1'b0;
    tick(1);
    chk("R9 data after resume", 0, 0, S_DATA);
    at_boundary = 1'b1;
    tick(1);
    chk("R9 back to idle", 0, 0, S_IDLE);
    at_boundary = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_grant_idle();
    t_release_pending();
    t_data_block();
    t_lock();
    t_priority();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule